// File: doc/BRIEF.md
# Tagged Result FIFO with Shift-Down Read

This block buffers the results of a multi-channel converter until a host collects them over a parallel port. Every finished conversion delivers two 12-bit results at once, each carrying a 3-bit channel code. Both results are written together as one pair. The buffer holds six entries. It always presents its oldest entry as a single 16-bit word: bit 15 marks the word valid, bits 14 to 12 hold the channel code, and bits 11 to 0 hold the result.

Storage is a stack of registers that shifts downward. A new pair always lands in the two lowest free slots, with the first result of the pair below the second. A read strobe marks that the host has finished reading the presented word. That entry is then dropped and every entry above it moves down by one slot. A pair that does not fit is refused whole, and a sticky overflow flag records the loss. Reset empties the stack and clears the flag.

Top module: `tagres_fifo`

## Requirements
- R1: A stored entry is presented as {1'b1, channel[2:0], result[11:0]}. Bit 15 is 1, bits 14:12 hold the channel code and bits 11:0 hold the result.
- R2: While the buffer holds no entry, `head_word` is 16'h0000.
- R3: A pair write is stored at the two lowest free slots, first result below second. Pairs are therefore read out in arrival order, and within a pair the first result comes out before the second.
- R4: A read strobe while at least one entry is stored drops the presented entry, and every other entry moves down one slot.
- R5: Reset, active low, empties all six slots and clears `ovf_flag`.
- R6: A read strobe and a pair write in the same cycle apply the shift first. The new pair then lands at the lowest slots that are free after the shift, so a pair that fits only because of the shift is accepted.
- R7: A pair write that would take the fill level above six is dropped whole, leaving the stored entries unchanged. It sets `ovf_flag`, which stays at 1 until reset.
- R8: A read strobe while the buffer is empty changes nothing. `head_word` stays 16'h0000.
- R9: `head_word` and `ovf_flag` are registered. A strobe sampled at a rising clock edge shows its effect only after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pair_we | input | 1 | Write strobe for one result pair |
| tag0 | input | 3 | Channel code of the first result |
| data0 | input | 12 | First result |
| tag1 | input | 3 | Channel code of the second result |
| data1 | input | 12 | Second result |
| rd_strobe | input | 1 | Read-complete strobe for the presented word |
| head_word | output | 16 | Oldest entry, or zero when empty |
| ovf_flag | output | 1 | Sticky flag for a refused pair |

## Verification
The assertions check on every cycle how the fill level may move. A pop lowers it by one and an accepted pair raises it by two. A refused pair leaves it unchanged and sets the flag, and the flag never falls before reset. The assertions also check that the valid bit of the head agrees with the fill level, and that the level never exceeds six. Only the bench can show which entry appears at the head after each operation: the arrival ordering, the first-below-second placement within a pair, and the shift-then-write order in a shared cycle. It shows these by sweeping every six-step sequence of write and read strobes against its own model of the stack.

// File: rtl/tagres_pkg.sv
package tagres_pkg;
  localparam int TAG_W  = 3;
  localparam int DATA_W = 12;
  localparam int WORD_W = 1 + TAG_W + DATA_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  // Build a presented word from a channel code and a result.
  function automatic word_t pack_word(input tag_t tag, input data_t data);
    return {1'b1, tag, data};
  endfunction

  // Level left after an optional pop.
  function automatic int level_after_pop(input int level, input logic pop);
    return pop ? level - 1 : level;
  endfunction

  // Whether two more entries fit above the given level.
  function automatic logic pair_fits(input int level, input int depth);
    return (level + 2) <= depth;
  endfunction
endpackage

// File: rtl/tagres_ctrl.sv
module tagres_ctrl #(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_we,
  input  logic             rd_strobe,
  output logic [CNT_W-1:0] fill_cnt,
  output logic [CNT_W-1:0] base_slot,
  output logic             pop_evt,
  output logic             push_evt,
  output logic             drop_evt,
  output logic             ovf_flag
);
  import tagres_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_q;
  int               lvl_after;

  always_comb begin
    pop_evt   = rd_strobe && (cnt_q != '0);
    lvl_after = level_after_pop(int'(cnt_q), pop_evt);
    push_evt  = pair_we && pair_fits(lvl_after, DEPTH);
    drop_evt  = pair_we && !push_evt;
    base_slot = CNT_W'(lvl_after);
    cnt_d     = push_evt ? CNT_W'(lvl_after + 2) : CNT_W'(lvl_after);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (drop_evt) ovf_q <= 1'b1;
    end
  end

  assign fill_cnt = cnt_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/tagres_slot.sv
module tagres_slot (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_lo,
  input  logic                  load_hi,
  input  logic                  shift,
  input  tagres_pkg::word_t     word_lo,
  input  tagres_pkg::word_t     word_hi,
  input  tagres_pkg::word_t     upper,
  output tagres_pkg::word_t     q
);
  tagres_pkg::word_t q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)       q_r <= '0;
    else if (load_lo) q_r <= word_lo;
    else if (load_hi) q_r <= word_hi;
    else if (shift)   q_r <= upper;
  end

  assign q = q_r;
endmodule

// File: rtl/tagres_fifo.sv
module tagres_fifo #(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pair_we,
  input  logic [2:0]  tag0,
  input  logic [11:0] data0,
  input  logic [2:0]  tag1,
  input  logic [11:0] data1,
  input  logic        rd_strobe,
  output logic [15:0] head_word,
  output logic        ovf_flag
);
  import tagres_pkg::*;

  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] base_slot;
  logic [CNT_W-1:0] base_next;
  logic             pop_evt;
  logic             push_evt;
  logic             drop_evt;
  word_t            word_lo;
  word_t            word_hi;
  word_t            slot_q [DEPTH];

  assign word_lo   = pack_word(tag0, data0);
  assign word_hi   = pack_word(tag1, data1);
  assign base_next = base_slot + 1'b1;

  tagres_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_we   (pair_we),
    .rd_strobe (rd_strobe),
    .fill_cnt  (fill_cnt),
    .base_slot (base_slot),
    .pop_evt   (pop_evt),
    .push_evt  (push_evt),
    .drop_evt  (drop_evt),
    .ovf_flag  (ovf_flag)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    word_t upper_w;
    logic  ld_lo;
    logic  ld_hi;
    if (i == DEPTH - 1) begin : g_top
      assign upper_w = '0;
    end else begin : g_mid
      assign upper_w = slot_q[i+1];
    end
    assign ld_lo = push_evt && (base_slot == CNT_W'(i));
    assign ld_hi = push_evt && (base_next == CNT_W'(i));
    tagres_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_lo (ld_lo),
      .load_hi (ld_hi),
      .shift   (pop_evt),
      .word_lo (word_lo),
      .word_hi (word_hi),
      .upper   (upper_w),
      .q       (slot_q[i])
    );
  end

  assign head_word = slot_q[0];
endmodule

// File: rtl/tagres_fifo_chk.sv
module tagres_fifo_chk #(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_strobe,
  input logic [15:0]      head_word,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             pop_evt,
  input logic             push_evt,
  input logic             drop_evt
);
  a_r2_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == '0) |-> (head_word == 16'h0000));

  a_r1_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt != '0) |-> head_word[15]);

  a_r4_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_cnt) <= DEPTH);

  a_r4_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt) |=> (fill_cnt == $past(fill_cnt) - 1'b1));

  a_r3_push_level: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> (int'(fill_cnt) == int'($past(fill_cnt)) - int'($past(pop_evt)) + 2));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  a_r7_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_flag);

  a_r7_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !pop_evt) |=> $stable(fill_cnt));

  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && fill_cnt == '0 && !push_evt) |=> (fill_cnt == '0));
endmodule

bind tagres_fifo tagres_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_strobe (rd_strobe),
  .head_word (head_word),
  .ovf_flag  (ovf_flag),
  .fill_cnt  (fill_cnt),
  .pop_evt   (pop_evt),
  .push_evt  (push_evt),
  .drop_evt  (drop_evt)
);

// File: tb/tagres_fifo_tb.sv
module tagres_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 6;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pair_we = 1'b0;
  logic [2:0]  tag0 = '0;
  logic [11:0] data0 = '0;
  logic [2:0]  tag1 = '0;
  logic [11:0] data1 = '0;
  logic        rd_strobe = 1'b0;
  logic [15:0] head_word;
  logic        ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  logic [15:0] m_q [NSLOT];
  int          m_cnt;
  logic        m_ovf;

  tagres_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .pair_we(pair_we),
    .tag0(tag0), .data0(data0), .tag1(tag1), .data1(data1),
    .rd_strobe(rd_strobe), .head_word(head_word), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_head();
    return (m_cnt > 0) ? m_q[0] : 16'h0000;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pair_we = 1'b0; rd_strobe = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_ovf = 1'b0;
    for (int k = 0; k < NSLOT; k++) m_q[k] = '0;
  endtask

  // One cycle of stimulus; model updated from the requirements, outputs checked mid-cycle.
  task automatic step(input bit we, input bit rd, input logic [2:0] ta, input logic [11:0] da,
                      input logic [2:0] tb, input logic [11:0] db, input bit do_chk);
    string req;
    bit popped;
    @(negedge clk);
    pair_we = we; rd_strobe = rd;
    tag0 = ta; data0 = da; tag1 = tb; data1 = db;
    @(posedge clk);
    popped = rd && (m_cnt > 0);
    if (popped) begin
      for (int k = 0; k < NSLOT - 1; k++) m_q[k] = m_q[k+1];
      m_q[NSLOT-1] = '0;
      m_cnt--;
    end
    if (we) begin
      if (m_cnt + 2 <= NSLOT) begin
        m_q[m_cnt]   = {1'b1, ta, da};
        m_q[m_cnt+1] = {1'b1, tb, db};
        m_cnt += 2;
      end else m_ovf = 1'b1;
    end
    #(CLK_PERIOD/4);
    pair_we = 1'b0; rd_strobe = 1'b0;
    if (do_chk) begin
      if (we && rd && popped)        req = "R6 shift-then-write";
      else if (we && !(m_cnt >= 2 && m_q[m_cnt-1] == {1'b1, tb, db})) req = "R7 refused pair";
      else if (rd && !popped)        req = "R8 read on empty";
      else if (popped)               req = "R4 shift-down read";
      else if (we)                   req = "R3 lowest free slot";
      else                           req = "R2 idle";
      check(req, head_word, exp_head());
      check({req, " / R7 ovf flag"}, {15'd0, ovf_flag}, {15'd0, m_ovf});
    end
  endtask

  initial begin
    // R5: reset state
    do_reset();
    @(negedge clk);
    check("R5 reset head", head_word, 16'h0000);
    check("R5 reset ovf", {15'd0, ovf_flag}, 16'h0000);
    check("R2 empty head", head_word, 16'h0000);

    // R1: field layout swept over every channel code, read back in pair order
    for (int t = 0; t < 8; t++) begin
      step(1'b1, 1'b0, 3'(t), 12'(t * 291 + 5), 3'(7 - t), 12'(4095 - t * 17), 1'b0);
      check("R1 first word layout", head_word, {1'b1, 3'(t), 12'(t * 291 + 5)});
      step(1'b0, 1'b1, '0, '0, '0, '0, 1'b0);
      check("R1 second word layout", head_word, {1'b1, 3'(7 - t), 12'(4095 - t * 17)});
      step(1'b0, 1'b1, '0, '0, '0, '0, 1'b0);
      check("R2 empty after drain", head_word, 16'h0000);
    end

    // R9: before the edge a read strobe has not yet taken effect
    step(1'b1, 1'b0, 3'd2, 12'h0AA, 3'd3, 12'h0BB, 1'b1);
    @(negedge clk);
    rd_strobe = 1'b1;
    #1;
    check("R9 head held before edge", head_word, 16'hA0AA);
    @(posedge clk);
    #(CLK_PERIOD/4);
    rd_strobe = 1'b0;
    check("R9 head after edge", head_word, 16'hB0BB);

    // R7 then R5: overflow, then reset clears it
    do_reset();
    for (int p = 0; p < 4; p++)
      step(1'b1, 1'b0, 3'(p), 12'(p + 1), 3'(p), 12'(p + 100), 1'b1);
    check("R7 flag raised", {15'd0, ovf_flag}, 16'h0001);
    do_reset();
    @(negedge clk);
    check("R5 ovf cleared", {15'd0, ovf_flag}, 16'h0000);
    check("R5 head cleared", head_word, 16'h0000);

    // Exhaustive: every 6-step sequence of {write, read} strobes
    for (int pat = 0; pat < 4096; pat++) begin
      do_reset();
      for (int s = 0; s < 6; s++) begin
        bit w, r;
        w = pat[2*s];
        r = pat[2*s+1];
        step(w, r, 3'((2 * s + pat) % 8), 12'((pat * 7 + s * 13) % 4096),
             3'((2 * s + 1 + pat) % 8), 12'((pat * 11 + s * 29 + 1) % 4096), 1'b1);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule